// File: doc/BRIEF.md
# Seven-Digit Ternary Ripple-Carry Adder

This block adds two unsigned base-3 numbers of seven digits each. It returns a seven-digit sum and one carry digit. Each digit (trit) takes one of the values 0, 1 or 2 and is carried on a pair of binary wires. The positive rail is high when the digit is 1 or 2. The negative rail is high only when the digit is 2.

The least significant digit is handled by a two-input cell. The six digits above it are handled by three-input cells, and each of those takes the carry from the cell below. Every cell forms its carry directly from its own input digits. Its sum digit comes from two two-input modulo-3 stages in series. The block is purely combinational.

A flag output marks any operand digit whose rails hold the one unused code. That code is negative rail high with positive rail low.

Top module: `tern_ripple_adder`

## Requirements
- R1: Digit encoding on a rail pair {pos, neg}: value 0 is {0,0}, value 1 is {1,0} and value 2 is {1,1}. Bit i of each rail vector holds digit i, with digit 0 least significant.
- R2: For legal operands A and B (digit weights 3^i), the sum digits read as a base-3 number, plus 2187 times the carry-out digit, equal A + B.
- R3: The digit-0 cell emits a carry of 0 or 1, never 2, so every carry in the chain stays below 2.
- R4: A digit cell at position 1 or above emits carry 0 when its three input digits total 0 to 2, carry 1 for totals 3 to 5, and carry 2 for a total of 6.
- R5: Each sum digit equals (a_i + b_i + carry-in_i) mod 3, with carry-in_0 = 0.
- R6: A carry produced at digit 0 travels through all seven positions. 2222222 + 0000001 gives sum 0000000 with carry-out 1.
- R7: `bad_code` is 1 exactly when some operand digit holds the unused pair {pos=0, neg=1}. A digit of value 2 does not raise it.
- R8: When every input digit is legal, no output digit (the sum digits and the carry-out) ever shows {pos=0, neg=1}.
- R9: All-zero operands give an all-zero sum, carry-out 0 and `bad_code` 0. The largest operands, 2222222 + 2222222, give sum 2222221 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_pos | input | 7 | Operand A, positive rail per digit |
| a_neg | input | 7 | Operand A, negative rail per digit |
| b_pos | input | 7 | Operand B, positive rail per digit |
| b_neg | input | 7 | Operand B, negative rail per digit |
| s_pos | output | 7 | Sum, positive rail per digit |
| s_neg | output | 7 | Sum, negative rail per digit |
| cout_pos | output | 1 | Carry-out digit, positive rail |
| cout_neg | output | 1 | Carry-out digit, negative rail |
| bad_code | output | 1 | High when any operand digit holds the unused rail pair |

## Verification
Two things can happen in the same input pattern: a carry generated at digit 0 that must ripple through every upper cell, and a sum digit that wraps modulo 3 at the same position as that carry. The bench provokes this with directed operands such as 2222222 + 1 and 1111112 + 2. It also sweeps every digit and carry-in combination at one middle position while the lower digits force a carry-in. Each result is judged by converting the rails back to integers and comparing them with plain integer addition. Every output digit is also checked for legal rail codes.

// File: rtl/tern_pkg.sv
`timescale 1ns/1ps
package tern_pkg;

    // One ternary digit on two binary rails.
    typedef struct packed {
        logic pos;   // high for values 1 and 2
        logic neg;   // high for value 2 only
    } trit_t;

    localparam trit_t TRIT_ZERO = '{pos: 1'b0, neg: 1'b0};

    // Unused rail code: negative high while positive low.
    function automatic logic trit_bad(trit_t t);
        return t.neg & ~t.pos;
    endfunction

    // Rail value as a 2-bit number (0..2) for legal codes.
    function automatic logic [1:0] trit_weight(trit_t t);
        return {1'b0, t.pos} + {1'b0, t.neg};
    endfunction

endpackage

// File: rtl/tern_sum_stage.sv
`timescale 1ns/1ps
// Two-input modulo-3 sum, evaluated directly on the rails.
module tern_sum_stage
    import tern_pkg::*;
(
    input  trit_t x,
    input  trit_t y,
    output trit_t s
);
    logic x0, x1, x2, y0, y1, y2;
    logic r1, r2;

    always_comb begin
        x0 = ~x.pos;
        x1 = x.pos & ~x.neg;
        x2 = x.neg;
        y0 = ~y.pos;
        y1 = y.pos & ~y.neg;
        y2 = y.neg;
        // result is 1 for 0+1, 1+0, 2+2
        r1 = (x0 & y1) | (x1 & y0) | (x2 & y2);
        // result is 2 for 0+2, 1+1, 2+0
        r2 = (x0 & y2) | (x1 & y1) | (x2 & y0);
        s.pos = r1 | r2;
        s.neg = r2;
    end
endmodule

// File: rtl/tern_half_cell.sv
`timescale 1ns/1ps
// Lowest digit: two operands, no carry in.
module tern_half_cell
    import tern_pkg::*;
(
    input  trit_t a,
    input  trit_t b,
    output trit_t s,
    output trit_t cy
);
    tern_sum_stage u_sum (.x(a), .y(b), .s(s));

    // a+b >= 3 happens for 1+2, 2+1, 2+2; the carry can never be 2.
    always_comb begin
        cy.pos = (a.neg & b.pos) | (a.pos & b.neg);
        cy.neg = 1'b0;
    end
endmodule

// File: rtl/tern_full_cell.sv
`timescale 1ns/1ps
// Upper digit: two operands plus carry in.
module tern_full_cell
    import tern_pkg::*;
(
    input  trit_t a,
    input  trit_t b,
    input  trit_t ci,
    output trit_t s,
    output trit_t cy
);
    trit_t       part;
    logic [2:0]  total;

    // Sum: two modulo-3 stages in series.
    tern_sum_stage u_sum_ab (.x(a),    .y(b),  .s(part));
    tern_sum_stage u_sum_c  (.x(part), .y(ci), .s(s));

    // Carry depends only on the total of the three digits, formed from
    // the inputs directly (each rail contributes one unit of weight).
    always_comb begin
        total  = {1'b0, trit_weight(a)} + {1'b0, trit_weight(b)}
               + {1'b0, trit_weight(ci)};
        cy.pos = (total >= 3'd3);
        cy.neg = a.neg & b.neg & ci.neg;
    end
endmodule

// File: rtl/tern_ripple_adder.sv
`timescale 1ns/1ps
module tern_ripple_adder
    import tern_pkg::*;
#(
    parameter int DIGITS = 7
) (
    input  logic [DIGITS-1:0] a_pos,
    input  logic [DIGITS-1:0] a_neg,
    input  logic [DIGITS-1:0] b_pos,
    input  logic [DIGITS-1:0] b_neg,
    output logic [DIGITS-1:0] s_pos,
    output logic [DIGITS-1:0] s_neg,
    output logic              cout_pos,
    output logic              cout_neg,
    output logic              bad_code
);
    // cy_*[k] is the carry leaving digit k-1 and entering digit k.
    logic [DIGITS:1] cy_pos;
    logic [DIGITS:1] cy_neg;

    trit_t op_a [DIGITS];
    trit_t op_b [DIGITS];
    trit_t res  [DIGITS];
    trit_t cyo  [DIGITS];

    logic [DIGITS-1:0] bad_a, bad_b;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        assign op_a[i]  = '{pos: a_pos[i], neg: a_neg[i]};
        assign op_b[i]  = '{pos: b_pos[i], neg: b_neg[i]};
        assign bad_a[i] = trit_bad(op_a[i]);
        assign bad_b[i] = trit_bad(op_b[i]);
        assign s_pos[i] = res[i].pos;
        assign s_neg[i] = res[i].neg;
        assign cy_pos[i+1] = cyo[i].pos;
        assign cy_neg[i+1] = cyo[i].neg;

        if (i == 0) begin : g_low
            tern_half_cell u_cell (
                .a  (op_a[i]),
                .b  (op_b[i]),
                .s  (res[i]),
                .cy (cyo[i])
            );
        end else begin : g_up
            trit_t cin;
            assign cin = '{pos: cy_pos[i], neg: cy_neg[i]};
            tern_full_cell u_cell (
                .a  (op_a[i]),
                .b  (op_b[i]),
                .ci (cin),
                .s  (res[i]),
                .cy (cyo[i])
            );
        end
    end

    assign cout_pos = cy_pos[DIGITS];
    assign cout_neg = cy_neg[DIGITS];
    assign bad_code = (|bad_a) | (|bad_b);

endmodule

// File: rtl/tern_adder_chk.sv
`timescale 1ns/1ps
module tern_adder_chk #(
    parameter int DIGITS = 7
) (
    input logic [DIGITS-1:0] a_pos,
    input logic [DIGITS-1:0] a_neg,
    input logic [DIGITS-1:0] b_pos,
    input logic [DIGITS-1:0] b_neg,
    input logic [DIGITS-1:0] s_pos,
    input logic [DIGITS-1:0] s_neg,
    input logic              cout_pos,
    input logic              cout_neg,
    input logic              bad_code,
    input logic [DIGITS:1]   cy_pos,
    input logic [DIGITS:1]   cy_neg
);
    always_comb begin
        if (!bad_code) begin
            // R8
            out_legal_chk: assert (((s_neg & ~s_pos) == '0) && !(cout_neg && !cout_pos))
                else $error("R8: illegal output rail pair");
            // R3
            no_carry_two_chk: assert (cy_neg == '0)
                else $error("R3: carry of value 2 in chain");
            // R4
            top_carry_chk: assert (!cout_pos || (a_pos[DIGITS-1] && b_pos[DIGITS-1])
                                   || a_neg[DIGITS-1] || b_neg[DIGITS-1])
                else $error("R4: carry-out without enough top-digit weight");
            for (int k = 1; k < DIGITS; k++) begin
                // R5
                zero_digit_chk: assert (a_pos[k] || b_pos[k] || cy_pos[k]
                                        || (!s_pos[k] && !cy_pos[k+1]))
                    else $error("R5: zero inputs gave nonzero digit %0d", k);
            end
        end
    end
endmodule

bind tern_ripple_adder tern_adder_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/test_tern_ripple_adder.sv
`timescale 1ns/1ps
module test_tern_ripple_adder;
    localparam int N = 7;
    localparam int RANGE = 2187;   // 3^7

    logic clk = 1'b0;
    always #2 clk = ~clk;          // 250 MHz

    logic [N-1:0] a_pos, a_neg, b_pos, b_neg, s_pos, s_neg;
    logic cout_pos, cout_neg, bad_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    tern_ripple_adder i_tern_ripple_adder (.*);

    function automatic int pow3(int e);
        int p = 1;
        for (int i = 0; i < e; i++) p = p * 3;
        return p;
    endfunction

    // R1 encoding: 0 -> {0,0}, 1 -> {1,0}, 2 -> {1,1}
    task automatic load(input int A, input int B);
        for (int i = 0; i < N; i++) begin
            int da = (A / pow3(i)) % 3;
            int db = (B / pow3(i)) % 3;
            a_pos[i] = (da != 0); a_neg[i] = (da == 2);
            b_pos[i] = (db != 0); b_neg[i] = (db == 2);
        end
    endtask

    function automatic int dec(input logic [N-1:0] p, input logic [N-1:0] n);
        int v = 0;
        for (int i = 0; i < N; i++) v += (int'(p[i]) + int'(n[i])) * pow3(i);
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One legal vector: R2 value, R8 legality, R7 flag low.
    task automatic add_vec(input string req, input int A, input int B);
        int got;
        @(negedge clk);
        load(A, B);
        #1;
        got = dec(s_pos, s_neg) + RANGE * (int'(cout_pos) + int'(cout_neg));
        check(req, got, A + B);
        check("R8", int'(((s_neg & ~s_pos) != '0) || (cout_neg && !cout_pos)), 0);
        check("R7", int'(bad_code), 0);
    endtask

    task automatic t_zero;   // R9 idle pattern
        @(negedge clk);
        load(0, 0);
        #1;
        check("R9 sum", int'({s_pos, s_neg}), 0);
        check("R9 cout", int'({cout_pos, cout_neg}), 0);
        check("R9 flag", int'(bad_code), 0);
    endtask

    task automatic t_extremes;  // R9, R6, R3
        add_vec("R9 max", RANGE - 1, RANGE - 1);
        check("R9 sum digits", dec(s_pos, s_neg), 2185);
        check("R9 cout", int'({cout_pos, cout_neg}), 2);  // {1,0} -> value 1
        add_vec("R6 ripple", RANGE - 1, 1);
        check("R6 sum zero", dec(s_pos, s_neg), 0);
        check("R6 cout", int'(cout_pos), 1);
        add_vec("R6 no carry", RANGE - 2, 1);
        check("R6 cout clear", int'(cout_pos), 0);
        add_vec("R3 low 2+2", 2, 2);
        check("R3 digit0", dec(s_pos, s_neg), 4);
        add_vec("R6 wrap", 1094, 2);
    endtask

    // R4/R5: every digit/carry-in combination at digit 3.
    task automatic t_mid_sweep;
        for (int c = 0; c < 2; c++)
            for (int x = 0; x < 3; x++)
                for (int y = 0; y < 3; y++) begin
                    int A = x * 27 + 26;
                    int B = y * 27 + c;
                    add_vec("R4 R5 sweep", A, B);
                    check("R5 digit3", ((dec(s_pos, s_neg) / 27) % 3), (x + y + c) % 3);
                    check("R4 carry3", ((dec(s_pos, s_neg) / 81) % 3), (x + y + c) / 3);
                end
    endtask

    task automatic t_random;   // R2 broad coverage
        for (int i = 0; i < 20000; i++)
            add_vec("R2 random", int'($urandom % RANGE), int'($urandom % RANGE));
    endtask

    task automatic t_flag;   // R7
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            load(1000, 500);
            a_pos[i] = 1'b0; a_neg[i] = 1'b1;
            #1;
            check("R7 bad A", int'(bad_code), 1);
            @(negedge clk);
            load(1000, 500);
            b_pos[i] = 1'b0; b_neg[i] = 1'b1;
            #1;
            check("R7 bad B", int'(bad_code), 1);
        end
        add_vec("R7 all twos", RANGE - 1, RANGE - 1);
    endtask

    initial begin
        a_pos = '0; a_neg = '0; b_pos = '0; b_neg = '0;
        t_zero();
        t_extremes();
        t_mid_sweep();
        t_flag();
        t_random();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule